// File: doc/BRIEF.md
# Dual-Channel PCM Time-Slot Serial Port

This block is the digital serial side of a two-channel voice codec. A single bit clock drives a shared serial bus. Each channel owns one transmit sync input and one receive sync input. When a sync input rises, that channel gets an 8-bit time slot on the bus. In a transmit slot, the channel's parallel sample is shifted out most significant bit first. In a receive slot, eight bits are gathered from the shared input pin and handed over as one parallel word together with a one-cycle strobe.

Output bits change on rising clock edges. Input bits are sampled on falling edges. The block drives the serial output only inside a transmit slot. It does this through a separate output-enable, and the pad's tri-state buffer uses that enable to float the pin at every other time. Sync pulses that collide or that land inside a running slot are reported as protocol errors. The coding-law select and the per-channel gain selects are decoded into status levels for the converter logic. The undriven defaults of those pins (μ-law and 0 dB) come from the pad's pull devices.

Top module: `pcm_tslot_port`

## Requirements
- R1: After reset, and whenever no transmit slot is running, `txOe` is low.
- R2: A rising edge on `fsTx[c]` seen at clock edge E0 loads the sample `txSample[8c+7:8c]`. `txOe` then goes high for exactly the 8 cycles after E0. `txPin` carries bit 7 in the first of those cycles and bit 0 in the last, changing only on rising edges.
- R3: A sync input held high for several cycles opens only one slot. Only the rising edge counts, not the level.
- R4: A rising edge on `fsRx[c]` seen at edge E0 makes the block sample `rxPin` on the 8 falling edges that follow E0..E7, most significant bit first. In the cycle after E8, `rxSample[8c+7:8c]` holds the word and `rxValid[c]` is high for exactly one cycle. At most one `rxValid` bit is high at a time.
- R5: Bits on `rxPin` outside a receive slot are ignored: `rxSample` keeps its value and `rxValid` stays low.
- R6: A sync rising exactly 8 cycles after the previous one in the same direction starts the next slot back to back. There is no idle cycle and no error.
- R7: A sync rising while a slot in the same direction is still before its last bit pulses that direction's error output (`txSyncErr` or `rxSyncErr`) for one cycle. The new slot replaces the old one.
- R8: If two syncs of one direction rise on the same edge, channel 0 takes the slot and the error output of that direction pulses for one cycle.
- R9: `lawAlaw` is high (A-law) when `lawSel` is high and low (μ-law) when `lawSel` is low. `gainCut[c]` is high (reduced gain) exactly when `gainSel[c]` is low.
- R10: While `rstN` is low, `txOe`, `rxValid`, both error outputs and `rxSample` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock of the serial bus |
| rstN | input | 1 | Active-low asynchronous reset |
| fsTx | input | 2 | Per-channel transmit sync, rising edge opens a slot |
| fsRx | input | 2 | Per-channel receive sync, rising edge opens a slot |
| txSample | input | 16 | Parallel transmit samples, channel c in bits 8c+7..8c |
| rxPin | input | 1 | Shared serial input |
| txPin | output | 1 | Shared serial output data, valid while txOe is high |
| txOe | output | 1 | Output enable for the pad's tri-state buffer |
| rxSample | output | 16 | Received words, channel c in bits 8c+7..8c |
| rxValid | output | 2 | One-cycle strobe per channel when a word lands |
| txSyncErr | output | 1 | One-cycle pulse on a transmit sync collision or mid-slot sync |
| rxSyncErr | output | 1 | One-cycle pulse on a receive sync collision or mid-slot sync |
| lawSel | input | 1 | Coding-law select, high for A-law |
| gainSel | input | 2 | Per-channel receive gain select, low for reduced gain |
| lawAlaw | output | 1 | Decoded law status |
| gainCut | output | 2 | Decoded reduced-gain status per channel |

## Verification
The bench targets the edges between slots. The first is a back-to-back pair of slots: a design that inserted an idle cycle would drop `txOe` in the cycle where the second slot starts. The second is a sync that arrives three bits into a slot: a design that ignored it would keep sending the old sample's bits and would not raise an error. A sync held high for three cycles would open extra slots in a level-sensitive design, and those slots show up as unexpected driven bits. Simultaneous syncs, stray receive bits with no slot open, and a receive word landing on the wrong channel or strobing for two cycles are each compared against the queued expectation.

// File: rtl/pcm_tslot_pkg.sv
package pcm_tslot_pkg;

  // channel index wide enough for up to 16 channels
  typedef logic [3:0] chIdx_t;

  // strobes from control to datapath, one set per clock
  typedef struct packed {
    logic   txLoad;   // capture a transmit sample into the shifter
    chIdx_t txLoadCh; // channel whose sample is captured
    logic   txShift;  // advance the transmit shifter by one bit
    logic   txDrive;  // a transmit slot is running
    logic   rxShift;  // take the bit latched on the last falling edge
    logic   rxDone;   // this shift completes the word
    chIdx_t rxCh;     // channel owning the running receive slot
  } slotStrobe_t;

endpackage

// File: rtl/pcm_slot_seq.sv
module pcm_slot_seq
  import pcm_tslot_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int SAMPLE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] fs,
  output logic              start,
  output chIdx_t            startCh,
  output logic              active,
  output logic              last,
  output chIdx_t            curCh,
  output logic              syncErr
);
  localparam int CNT_W = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1;

  logic [NUM_CH-1:0] fsPrev;
  logic [NUM_CH-1:0] rise;
  logic [CNT_W-1:0]  bitCnt;
  logic              multiRise;

  assign rise      = fs & ~fsPrev;
  assign start     = |rise;
  assign multiRise = (rise & (rise - NUM_CH'(1))) != '0;
  assign last      = active && (bitCnt == CNT_W'(SAMPLE_W - 1));

  // lowest index wins
  always_comb begin
    startCh = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (rise[i]) startCh = chIdx_t'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsPrev  <= '0;
      active  <= 1'b0;
      bitCnt  <= '0;
      curCh   <= '0;
      syncErr <= 1'b0;
    end else begin
      fsPrev  <= fs;
      syncErr <= start && ((active && !last) || multiRise);
      if (start) begin
        active <= 1'b1;
        bitCnt <= '0;
        curCh  <= startCh;
      end else if (active) begin
        if (last) active <= 1'b0;
        else      bitCnt <= bitCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_tslot_ctrl.sv
module pcm_tslot_ctrl
  import pcm_tslot_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int SAMPLE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] fsTx,
  input  logic [NUM_CH-1:0] fsRx,
  output slotStrobe_t       strobe,
  output logic              txSyncErr,
  output logic              rxSyncErr
);
  logic   txStart, txActive, txLast;
  chIdx_t txStartCh, txCurCh;
  logic   rxStart, rxActive, rxLast;
  chIdx_t rxStartCh, rxCurCh;

  pcm_slot_seq #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_txSeq (
    .clk(clk), .rstN(rstN), .fs(fsTx),
    .start(txStart), .startCh(txStartCh), .active(txActive),
    .last(txLast), .curCh(txCurCh), .syncErr(txSyncErr)
  );

  pcm_slot_seq #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_rxSeq (
    .clk(clk), .rstN(rstN), .fs(fsRx),
    .start(rxStart), .startCh(rxStartCh), .active(rxActive),
    .last(rxLast), .curCh(rxCurCh), .syncErr(rxSyncErr)
  );

  // the receive side never needs the start edge or the new owner:
  // a restarted slot simply begins shifting on the next edge
  logic unusedRx;
  assign unusedRx = rxStart ^ (|rxStartCh) ^ (|txCurCh);

  always_comb begin
    strobe          = '0;
    strobe.txLoad   = txStart;
    strobe.txLoadCh = txStartCh;
    strobe.txShift  = txActive && !txLast;
    strobe.txDrive  = txActive;
    strobe.rxShift  = rxActive;
    strobe.rxDone   = rxActive && rxLast;
    strobe.rxCh     = rxCurCh;
  end
endmodule

// File: rtl/pcm_tslot_datapath.sv
module pcm_tslot_datapath
  import pcm_tslot_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int SAMPLE_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  slotStrobe_t                strobe,
  input  logic [NUM_CH*SAMPLE_W-1:0] txSample,
  input  logic                       rxPin,
  output logic                       txPin,
  output logic                       txOe,
  output logic [NUM_CH*SAMPLE_W-1:0] rxSample,
  output logic [NUM_CH-1:0]          rxValid
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [SAMPLE_W-1:0] txWord [NUM_CH];
  logic [SAMPLE_W-1:0] txShReg;
  logic [SAMPLE_W-1:0] rxShReg;
  logic [SAMPLE_W-1:0] rxWord;
  logic                rxLatch;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_txWord
    assign txWord[c] = txSample[c*SAMPLE_W +: SAMPLE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShReg <= '0;
    end else if (strobe.txLoad) begin
      txShReg <= txWord[strobe.txLoadCh[CH_W-1:0]];
    end else if (strobe.txShift) begin
      txShReg <= {txShReg[SAMPLE_W-2:0], 1'b0};
    end
  end

  assign txPin = txShReg[SAMPLE_W-1];
  assign txOe  = strobe.txDrive;

  // receive bits are taken on the falling edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) rxLatch <= 1'b0;
    else       rxLatch <= rxPin;
  end

  assign rxWord = {rxShReg[SAMPLE_W-2:0], rxLatch};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rxShReg <= '0;
    else if (strobe.rxShift) rxShReg <= rxWord;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_rxHold
    logic landHere;
    assign landHere = strobe.rxDone && (strobe.rxCh[CH_W-1:0] == CH_W'(c));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rxSample[c*SAMPLE_W +: SAMPLE_W] <= '0;
        rxValid[c]                       <= 1'b0;
      end else begin
        rxValid[c] <= landHere;
        if (landHere) rxSample[c*SAMPLE_W +: SAMPLE_W] <= rxWord;
      end
    end
  end
endmodule

// File: rtl/pcm_tslot_port.sv
module pcm_tslot_port
  import pcm_tslot_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int SAMPLE_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_CH-1:0]          fsTx,
  input  logic [NUM_CH-1:0]          fsRx,
  input  logic [NUM_CH*SAMPLE_W-1:0] txSample,
  input  logic                       rxPin,
  output logic                       txPin,
  output logic                       txOe,
  output logic [NUM_CH*SAMPLE_W-1:0] rxSample,
  output logic [NUM_CH-1:0]          rxValid,
  output logic                       txSyncErr,
  output logic                       rxSyncErr,
  input  logic                       lawSel,
  input  logic [NUM_CH-1:0]          gainSel,
  output logic                       lawAlaw,
  output logic [NUM_CH-1:0]          gainCut
);
  slotStrobe_t strobe;

  pcm_tslot_ctrl #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .fsTx(fsTx), .fsRx(fsRx),
    .strobe(strobe), .txSyncErr(txSyncErr), .rxSyncErr(rxSyncErr)
  );

  pcm_tslot_datapath #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txSample(txSample),
    .rxPin(rxPin), .txPin(txPin), .txOe(txOe),
    .rxSample(rxSample), .rxValid(rxValid)
  );

  // status decode; undriven defaults come from the pad pulls
  assign lawAlaw = lawSel;
  assign gainCut = ~gainSel;
endmodule

// File: rtl/pcm_tslot_port_chk.sv
module pcm_tslot_port_chk #(
  parameter int NUM_CH   = 2,
  parameter int SAMPLE_W = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [NUM_CH-1:0]          fsTx,
  input logic [NUM_CH-1:0]          fsRx,
  input logic                       txOe,
  input logic [NUM_CH*SAMPLE_W-1:0] rxSample,
  input logic [NUM_CH-1:0]          rxValid,
  input logic                       txSyncErr,
  input logic                       rxSyncErr
);
  localparam int CW = $clog2(SAMPLE_W + 2);

  logic [NUM_CH-1:0] txPrev, rxPrev, txRise, rxRise;
  logic [CW-1:0]     sinceTx;

  assign txRise = fsTx & ~txPrev;
  assign rxRise = fsRx & ~rxPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPrev  <= '0;
      rxPrev  <= '0;
      sinceTx <= CW'(SAMPLE_W + 1);
    end else begin
      txPrev <= fsTx;
      rxPrev <= fsRx;
      if (txRise != '0)                  sinceTx <= CW'(1);
      else if (sinceTx <= CW'(SAMPLE_W)) sinceTx <= sinceTx + 1'b1;
    end
  end

  // R1
  tx_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceTx > CW'(SAMPLE_W)) |-> !txOe);

  // R2
  tx_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceTx != '0 && sinceTx <= CW'(SAMPLE_W)) |-> txOe);

  // R8
  tx_collide_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((txRise & (txRise - NUM_CH'(1))) != '0) |=> txSyncErr);

  // R8
  rx_collide_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rxRise & (rxRise - NUM_CH'(1))) != '0) |=> rxSyncErr);

  // R4
  rx_valid_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rxValid));

  // R5
  rx_hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid == '0) |-> $stable(rxSample));
endmodule

bind pcm_tslot_port pcm_tslot_port_chk #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rstN(rstN), .fsTx(fsTx), .fsRx(fsRx), .txOe(txOe),
  .rxSample(rxSample), .rxValid(rxValid),
  .txSyncErr(txSyncErr), .rxSyncErr(rxSyncErr)
);

// File: tb/pcm_tslot_port_tb.sv
module pcm_tslot_port_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  fsTx = '0, fsRx = '0;
  logic [15:0] txSample = '0;
  logic        rxPin = 1'b0;
  logic        txPin, txOe;
  logic [15:0] rxSample;
  logic [1:0]  rxValid;
  logic        txSyncErr, rxSyncErr;
  logic        lawSel = 1'b0;
  logic [1:0]  gainSel = 2'b11;
  logic        lawAlaw;
  logic [1:0]  gainCut;

  int nChk = 0, nBad = 0;
  int errTx = 0, errRx = 0;
  bit running = 1'b0;
  bit finished = 1'b0;
  logic     txQ [$];
  logic [8:0] rxQ [$];

  always #2 clk = ~clk;

  pcm_tslot_port u_dut (
    .clk(clk), .rstN(rstN), .fsTx(fsTx), .fsRx(fsRx), .txSample(txSample),
    .rxPin(rxPin), .txPin(txPin), .txOe(txOe), .rxSample(rxSample),
    .rxValid(rxValid), .txSyncErr(txSyncErr), .rxSyncErr(rxSyncErr),
    .lawSel(lawSel), .gainSel(gainSel), .lawAlaw(lawAlaw), .gainCut(gainCut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // driver: raise transmit syncs, queue the bits expected on the pin
  task automatic txSync(input logic [1:0] mask, input logic [7:0] d0,
                        input logic [7:0] d1, input int hold);
    logic [7:0] w;
    logic keep;
    txSample = {d1, d0};
    fsTx     = mask;
    w        = mask[0] ? d0 : d1;
    if (txQ.size() > 0) begin
      keep = txQ[0];
      txQ.delete();
      txQ.push_back(keep);
    end
    for (int i = 7; i >= 0; i--) txQ.push_back(w[i]);
    cyc(hold);
    fsTx = '0;
  endtask

  // driver: open a receive slot and present its bits
  task automatic rxSlot(input logic [1:0] mask, input logic [7:0] d);
    fsRx = mask;
    rxQ.push_back({~mask[0], d});
    cyc(1);
    fsRx  = '0;
    rxPin = d[7];
    for (int i = 6; i >= 0; i--) begin
      cyc(1);
      rxPin = d[i];
    end
  endtask

  // monitor: compare outputs against the queues mid-cycle
  always @(negedge clk) begin
    if (rstN && running) begin
      if (txOe) begin
        if (txQ.size() == 0) check(1'b0, "R1", "unexpected drive", 1, 0);
        else begin
          logic e;
          e = txQ.pop_front();
          check(txPin == e, "R2", "tx bit", int'(txPin), int'(e));
        end
      end
      if (rxValid != '0) begin
        check(rxValid == 2'b01 || rxValid == 2'b10, "R4", "valid onehot",
              int'(rxValid), 1);
        if (rxQ.size() == 0) check(1'b0, "R5", "unexpected rx word", int'(rxValid), 0);
        else begin
          logic [8:0] e;
          logic [7:0] got;
          e   = rxQ.pop_front();
          got = rxValid[1] ? rxSample[15:8] : rxSample[7:0];
          check(rxValid[e[8]], "R4", "rx channel", int'(rxValid), 1 << e[8]);
          check(got == e[7:0], "R4", "rx word", int'(got), int'(e[7:0]));
        end
      end
      errTx += int'(txSyncErr);
      errRx += int'(rxSyncErr);
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [15:0] snap;
    cyc(3);
    // R10 reset state while held in reset
    check(!txOe && rxValid == 0 && rxSample == 0 && !txSyncErr && !rxSyncErr,
          "R10", "reset outputs", int'({txOe, rxValid, txSyncErr, rxSyncErr}), 0);
    rstN = 1'b1;
    running = 1'b1;
    cyc(2);
    check(!txOe, "R1", "idle after reset", int'(txOe), 0);
    // R9 decode
    check(lawAlaw == 1'b0 && gainCut == 2'b00, "R9", "mu-law/0dB",
          int'({lawAlaw, gainCut}), 0);
    lawSel = 1'b1; gainSel = 2'b10; #1;
    check(lawAlaw == 1'b1 && gainCut == 2'b01, "R9", "A-law/ch0 cut",
          int'({lawAlaw, gainCut}), 3'b101);

    // R2 single slot, R3 sync held for three cycles
    txSync(2'b01, 8'hA5, 8'h00, 1);
    cyc(12);
    txSync(2'b10, 8'h00, 8'h3C, 3);
    cyc(14);
    check(!txOe, "R1", "released after slot", int'(txOe), 0);
    check(txQ.size() == 0, "R3", "bits left over", txQ.size(), 0);

    // R6 back-to-back transmit slots
    txSync(2'b01, 8'h81, 8'h00, 1);
    cyc(7);
    txSync(2'b10, 8'h00, 8'h7E, 1);
    check(txOe && txPin == 1'b0, "R6", "seamless second slot",
          int'({txOe, txPin}), 2'b10);
    cyc(12);
    check(errTx == 0, "R6", "tx err count", errTx, 0);

    // R7 sync inside a running slot
    txSync(2'b01, 8'hFF, 8'h00, 1);
    cyc(2);
    txSync(2'b10, 8'h00, 8'h00, 1);
    cyc(12);
    check(errTx == 1, "R7", "tx err count", errTx, 1);
    check(txQ.size() == 0, "R7", "bits left over", txQ.size(), 0);

    // R8 simultaneous transmit syncs
    txSync(2'b11, 8'h5A, 8'hC3, 1);
    cyc(12);
    check(errTx == 2, "R8", "tx err count", errTx, 2);
    check(txQ.size() == 0, "R8", "bits left over", txQ.size(), 0);

    // R4 receive slots, R6 back to back on receive
    rxSlot(2'b01, 8'h96);
    cyc(3);
    rxSlot(2'b10, 8'h4B);
    rxSlot(2'b01, 8'h3C);
    cyc(4);
    check(rxQ.size() == 0, "R4", "words missing", rxQ.size(), 0);
    check(rxSample == 16'h4B3C, "R4", "held words", int'(rxSample), 16'h4B3C);
    check(errRx == 0, "R6", "rx err count", errRx, 0);

    // R5 stray receive bits
    snap = rxSample;
    for (int i = 0; i < 16; i++) begin
      rxPin = ~rxPin ^ i[1];
      cyc(1);
    end
    cyc(2);
    check(rxSample == snap, "R5", "stray bits", int'(rxSample), int'(snap));

    // R8 simultaneous receive syncs
    rxSlot(2'b11, 8'hE1);
    cyc(4);
    check(errRx == 1, "R8", "rx err count", errRx, 1);
    check(rxSample[7:0] == 8'hE1 && rxSample[15:8] == 8'h4B, "R8",
          "rx winner", int'(rxSample), 16'h4BE1);
    check(rxQ.size() == 0, "R8", "words missing", rxQ.size(), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule